// File: doc/BRIEF.md
# Planar Pixel to Palette Index Mapper

This block sits in a display path between the plane fetch logic and the colour palette. Each dot clock it may accept a 4-bit planar pixel value, one bit per memory plane, and turn it into an 8-bit palette index. Normally the index comes from a lookup: a per-plane enable mask first clears the bits of disabled planes. The masked value then picks one of sixteen 6-bit colour registers. The top two index bits come from a shared colour-select field. A second global field can optionally replace index bits 5:4.

In a 256-colour packed mode the lookup is skipped. Two successive accepted pixel values are joined into one 8-bit index, so one index leaves every other accepted pixel. A video-enable input blanks the index to zero while the output strobe keeps its timing. A pixel mask is applied last. Two status bits show a selectable pair of bits of the final index.

Top module: `pal_index_mapper`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `idx_out` to 00h and `idx_valid` to 0, and it clears the packed-mode pairing state.
- R2: Each bit of `pix_planes` is ANDed with the same-numbered bit of `plane_en` before any other use, in both lookup and packed mode, so a disabled plane contributes 0.
- R3: In lookup mode, the masked value k selects colour register k, held in `colour_regs[6k+5:6k]`. That register supplies index bits 5:0, except as R5 states.
- R4: In lookup mode, index bits 7:6 equal `col_sel[3:2]` for every colour.
- R5: In lookup mode with `alt_sel` = 1, index bits 5:4 equal `col_sel[1:0]` and not bits 5:4 of the selected colour register. Bits 3:0 still come from the register.
- R6: With `packed_mode` = 1, accepted pixels are taken in pairs. The first masked value becomes index bits 7:4 and the second becomes bits 3:0. Colour registers and `col_sel` have no effect. `idx_valid` is raised only for the second pixel of a pair. While `packed_mode` is 0, the pairing restarts, so the next packed pixel is again a first.
- R7: When `video_en` is 0 for an accepted result, the output index is 00h and `idx_valid` is still raised.
- R8: The output index is the computed index ANDed bit by bit with `pix_mask`.
- R9: `stat_sel` chooses which bits of `idx_out` drive `{stat_hi, stat_lo}`: 0 gives bits {2,0}, 1 gives {5,4}, 2 gives {3,1}, 3 gives {7,6}.
- R10: A result is registered on the clock edge that accepts its input. `idx_out` and `idx_valid` change one dot clock after that input. When no result is produced, `idx_valid` is 0 and `idx_out` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | Pixel value present this cycle |
| pix_planes | input | 4 | Planar pixel value, one bit per plane |
| plane_en | input | 4 | Per-plane enable mask |
| colour_regs | input | 96 | Sixteen 6-bit colour registers, register k at bits 6k+5:6k |
| col_sel | input | 4 | Bits 3:2 give index 7:6; bits 1:0 are the alternate index 5:4 |
| alt_sel | input | 1 | Take index 5:4 from col_sel[1:0] |
| packed_mode | input | 1 | 256-colour nibble packing, lookup bypassed |
| video_en | input | 1 | 0 forces the index to 00h |
| pix_mask | input | 8 | Final AND mask on the index |
| stat_sel | input | 2 | Status bit pair select |
| idx_out | output | 8 | Palette index |
| idx_valid | output | 1 | idx_out carries a new result |
| stat_hi | output | 1 | Selected status bit (upper of pair) |
| stat_lo | output | 1 | Selected status bit (lower of pair) |

## Verification
Every result is due exactly one dot clock after the accepted pixel. The bench drives inputs on the falling edge, lets one rising edge pass, and samples shortly after it. This is the cycle in which R10 says the index and strobe appear. In packed mode the bench checks that the strobe stays low after the first pixel of a pair, and it compares the joined index after the second. The status bits are combinational from the registered index, so the bench checks them in the same sample as the index they reflect.

// File: rtl/pim_pkg.sv
// Shared definitions for the planar pixel to palette index mapper.
// Assumes an 8-bit index, so the fixed status bit positions exist.
package pim_pkg;
    localparam int PIM_PLANES = 4;
    localparam int PIM_CREG_W = 6;

    // Status pair selection codes
    typedef enum logic [1:0] {
        STAT_B2_B0 = 2'd0,
        STAT_B5_B4 = 2'd1,
        STAT_B3_B1 = 2'd2,
        STAT_B7_B6 = 2'd3
    } stat_sel_e;
endpackage

// File: rtl/pim_lookup.sv
// Lookup path: masks plane bits, selects a colour register and adds
// the shared upper bits plus the optional alternate middle bits.
// Assumes IDX_W - CREG_W upper bits and an alternate field of equal width.
module pim_lookup #(
    parameter int PLANES = 4,
    parameter int CREG_W = 6,
    parameter int IDX_W  = 2 * PLANES,
    localparam int NUM_COL = 1 << PLANES,
    localparam int UP_W    = IDX_W - CREG_W
) (
    input  logic [PLANES-1:0]        planes,
    input  logic [PLANES-1:0]        plane_en,
    input  logic [NUM_COL*CREG_W-1:0] colour_regs,
    input  logic [2*UP_W-1:0]        col_sel,
    input  logic                     alt_sel,
    output logic [PLANES-1:0]        masked_nib,
    output logic [IDX_W-1:0]         direct_idx
);
    logic [CREG_W-1:0] creg_pick;

    // Gate each plane bit with its enable
    generate
        for (genvar p = 0; p < PLANES; p++) begin : g_plane
            assign masked_nib[p] = planes[p] & plane_en[p];
        end
    endgenerate

    // Select the colour register addressed by the masked value
    always_comb begin
        creg_pick = '0;
        for (int k = 0; k < NUM_COL; k++) begin
            if (masked_nib == PLANES'(k)) begin
                creg_pick = colour_regs[k*CREG_W +: CREG_W];
            end
        end
    end

    // Compose upper, middle and lower index fields
    always_comb begin
        direct_idx = {col_sel[2*UP_W-1:UP_W], creg_pick};
        if (alt_sel) begin
            direct_idx[CREG_W-1 -: UP_W] = col_sel[UP_W-1:0];
        end
    end
endmodule

// File: rtl/pim_packer.sv
// Packed-mode pairing: holds the first nibble of a pair and joins it
// with the second, first nibble on top. Restarts whenever packing is off.
module pim_packer #(
    parameter int PLANES = 4,
    localparam int IDX_W = 2 * PLANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              packed_mode,
    input  logic [PLANES-1:0] nib,
    output logic              pack_valid,
    output logic [IDX_W-1:0]  pack_idx
);
    logic              phase_q;
    logic [PLANES-1:0] upper_q;

    // Track which half of a pair the next accepted nibble is
    always_ff @(posedge clk) begin
        if (!rst_n || !packed_mode) begin
            phase_q <= 1'b0;
        end else if (in_valid) begin
            phase_q <= ~phase_q;
        end
    end

    // Hold the first nibble of the pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
        end else if (in_valid && packed_mode && !phase_q) begin
            upper_q <= nib;
        end
    end

    assign pack_valid = in_valid && packed_mode && phase_q;
    assign pack_idx   = {upper_q, nib};

    // Second half of a pair always returns the pairing to its start
    p_pair_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && packed_mode && phase_q) |=> !phase_q);

    // Packing off always leaves the next nibble as a first half
    p_phase_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !packed_mode |=> !phase_q);
endmodule

// File: rtl/pim_out_stage.sv
// Output register: applies blanking and the pixel mask, registers the
// index with its strobe, and drives the status bit multiplexer.
module pim_out_stage
    import pim_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [IDX_W-1:0] cand_idx,
    input  logic             video_en,
    input  logic [IDX_W-1:0] pix_mask,
    input  logic [1:0]       stat_sel,
    output logic [IDX_W-1:0] idx_q,
    output logic             vld_q,
    output logic             stat_hi,
    output logic             stat_lo
);
    logic [IDX_W-1:0] final_idx;

    // Blank, then apply the pixel mask
    always_comb begin
        final_idx = video_en ? (cand_idx & pix_mask) : '0;
    end

    // Register the index and strobe one clock after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= take;
            if (take) begin
                idx_q <= final_idx;
            end
        end
    end

    // Select the status bit pair from the registered index
    always_comb begin
        unique case (stat_sel_e'(stat_sel))
            STAT_B2_B0: {stat_hi, stat_lo} = {idx_q[2], idx_q[0]};
            STAT_B5_B4: {stat_hi, stat_lo} = {idx_q[5], idx_q[4]};
            STAT_B3_B1: {stat_hi, stat_lo} = {idx_q[3], idx_q[1]};
            default:    {stat_hi, stat_lo} = {idx_q[7], idx_q[6]};
        endcase
    end

    p_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !video_en) |=> (vld_q && idx_q == '0));

    p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ((idx_q & ~$past(pix_mask)) == '0));

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> vld_q);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> (!vld_q && $stable(idx_q)));
endmodule

// File: rtl/pal_index_mapper.sv
// Top level: converts planar pixel values into palette indices through
// either the colour register lookup or the packed 256-colour path.
// Assumes one pixel per dot clock at most and static control inputs
// across a packed pair.
module pal_index_mapper
    import pim_pkg::*;
#(
    parameter int PLANES = PIM_PLANES,
    parameter int CREG_W = PIM_CREG_W,
    localparam int IDX_W   = 2 * PLANES,
    localparam int NUM_COL = 1 << PLANES,
    localparam int UP_W    = IDX_W - CREG_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pix_valid,
    input  logic [PLANES-1:0]         pix_planes,
    input  logic [PLANES-1:0]         plane_en,
    input  logic [NUM_COL*CREG_W-1:0] colour_regs,
    input  logic [2*UP_W-1:0]         col_sel,
    input  logic                      alt_sel,
    input  logic                      packed_mode,
    input  logic                      video_en,
    input  logic [IDX_W-1:0]          pix_mask,
    input  logic [1:0]                stat_sel,
    output logic [IDX_W-1:0]          idx_out,
    output logic                      idx_valid,
    output logic                      stat_hi,
    output logic                      stat_lo
);
    logic [PLANES-1:0] masked_nib;
    logic [IDX_W-1:0]  direct_idx;
    logic              pack_valid;
    logic [IDX_W-1:0]  pack_idx;
    logic              take;
    logic [IDX_W-1:0]  cand_idx;

    pim_lookup #(.PLANES(PLANES), .CREG_W(CREG_W), .IDX_W(IDX_W)) u_lookup (
        .planes      (pix_planes),
        .plane_en    (plane_en),
        .colour_regs (colour_regs),
        .col_sel     (col_sel),
        .alt_sel     (alt_sel),
        .masked_nib  (masked_nib),
        .direct_idx  (direct_idx)
    );

    pim_packer #(.PLANES(PLANES)) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (pix_valid),
        .packed_mode (packed_mode),
        .nib         (masked_nib),
        .pack_valid  (pack_valid),
        .pack_idx    (pack_idx)
    );

    // Choose the path feeding the output register
    always_comb begin
        take     = packed_mode ? pack_valid : pix_valid;
        cand_idx = packed_mode ? pack_idx : direct_idx;
    end

    pim_out_stage #(.IDX_W(IDX_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .cand_idx (cand_idx),
        .video_en (video_en),
        .pix_mask (pix_mask),
        .stat_sel (stat_sel),
        .idx_q    (idx_out),
        .vld_q    (idx_valid),
        .stat_hi  (stat_hi),
        .stat_lo  (stat_lo)
    );

    // Lookup-mode results appear one clock after the pixel
    p_direct_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !packed_mode) |=> idx_valid);

    // A completed pair lands in the output, blanked or masked
    p_pair_output_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pack_valid && video_en) |=> (idx_out == ($past(pack_idx) & $past(pix_mask))));
endmodule

// File: tb/pal_index_mapper_bench.sv
// Self-checking bench with sweeps over nibbles, enables, selects and pairs.
module pal_index_mapper_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0;
    logic [3:0]  pix_planes = '0;
    logic [3:0]  plane_en = 4'hF;
    logic [95:0] colour_regs;
    logic [3:0]  col_sel = '0;
    logic        alt_sel = 1'b0;
    logic        packed_mode = 1'b0;
    logic        video_en = 1'b1;
    logic [7:0]  pix_mask = 8'hFF;
    logic [1:0]  stat_sel = '0;
    logic [7:0]  idx_out;
    logic        idx_valid;
    logic        stat_hi;
    logic        stat_lo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pal_index_mapper u_pal_index_mapper (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_planes(pix_planes),
        .plane_en(plane_en), .colour_regs(colour_regs), .col_sel(col_sel),
        .alt_sel(alt_sel), .packed_mode(packed_mode), .video_en(video_en),
        .pix_mask(pix_mask), .stat_sel(stat_sel), .idx_out(idx_out),
        .idx_valid(idx_valid), .stat_hi(stat_hi), .stat_lo(stat_lo)
    );

    function automatic logic [5:0] creg(int k);
        return 6'((k * 23 + 11) % 64);
    endfunction

    // Lookup-mode index from the requirements
    function automatic logic [7:0] exp_direct(logic [3:0] nib);
        logic [3:0] m;
        logic [7:0] e;
        m = nib & plane_en;
        e = {col_sel[3:2], creg(int'(m))};
        if (alt_sel) e[5:4] = col_sel[1:0];
        if (!video_en) e = 8'h00;
        return e & pix_mask;
    endfunction

    function automatic logic [1:0] exp_stat(logic [7:0] e, logic [1:0] s);
        case (s)
            2'd0: return {e[2], e[0]};
            2'd1: return {e[5], e[4]};
            2'd2: return {e[3], e[1]};
            default: return {e[7], e[6]};
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, sample just after the rising edge
    task automatic step(logic v, logic [3:0] nib);
        @(negedge clk);
        pix_valid  = v;
        pix_planes = nib;
        @(posedge clk);
        #1;
    endtask

    task automatic direct_check(string req, logic [3:0] nib);
        logic [7:0] e;
        e = exp_direct(nib);
        step(1'b1, nib);
        check(req, {7'd0, idx_valid}, 8'd1);
        check(req, idx_out, e);
    endtask

    initial begin
        for (int k = 0; k < 16; k++) colour_regs[k*6 +: 6] = creg(k);
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 idx", idx_out, 8'h00);
        check("R1 valid", {7'd0, idx_valid}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 R4: lookup with each upper field
        for (int c = 0; c < 4; c++) begin
            col_sel = 4'(c << 2);
            for (int n = 0; n < 16; n++) direct_check("R3_R4 lookup", 4'(n));
        end

        // R2: plane enable sweep
        col_sel = 4'b1001;
        for (int p = 0; p < 16; p++) begin
            plane_en = 4'(p);
            for (int n = 0; n < 16; n++) direct_check("R2 plane_en", 4'(n));
        end
        plane_en = 4'hF;

        // R5: alternate middle bits
        alt_sel = 1'b1;
        for (int c = 0; c < 16; c++) begin
            col_sel = 4'(c);
            for (int n = 0; n < 16; n += 3) direct_check("R5 alt", 4'(n));
        end
        alt_sel = 1'b0;

        // R8: pixel mask
        for (int m = 0; m < 256; m += 17) begin
            pix_mask = 8'(m);
            for (int n = 0; n < 16; n += 5) direct_check("R8 mask", 4'(n));
        end
        pix_mask = 8'hFF;

        // R7: blanking keeps the strobe
        video_en = 1'b0;
        for (int n = 0; n < 16; n++) direct_check("R7 blank", 4'(n));
        video_en = 1'b1;

        // R9: status pair selection
        col_sel = 4'b1100;
        for (int s = 0; s < 4; s++) begin
            stat_sel = 2'(s);
            for (int n = 0; n < 16; n++) begin
                logic [7:0] e;
                e = exp_direct(4'(n));
                step(1'b1, 4'(n));
                check("R9 status", {6'd0, stat_hi, stat_lo}, {6'd0, exp_stat(e, 2'(s))});
            end
        end

        // R10: idle cycle drops the strobe and holds the index
        begin
            logic [7:0] e;
            e = exp_direct(4'd7);
            step(1'b1, 4'd7);
            step(1'b0, 4'd2);
            check("R10 idle valid", {7'd0, idx_valid}, 8'd0);
            check("R10 idle hold", idx_out, e);
        end

        // R6: packed pairs, lookup bypassed
        packed_mode = 1'b1;
        col_sel = 4'b0110;
        alt_sel = 1'b1;
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                step(1'b1, 4'(a));
                check("R6 first half", {7'd0, idx_valid}, 8'd0);
                step(1'b1, 4'(b));
                check("R6 pair valid", {7'd0, idx_valid}, 8'd1);
                check("R6 pair index", idx_out, {4'(a), 4'(b)});
            end
        end
        // R6 R2: plane enable applies before packing
        plane_en = 4'b0101;
        step(1'b1, 4'hF);
        step(1'b1, 4'hE);
        check("R6_R2 packed planes", idx_out, 8'h54);
        plane_en = 4'hF;
        // R6: leaving packed mode restarts the pairing
        step(1'b1, 4'h3);
        packed_mode = 1'b0;
        alt_sel = 1'b0;
        direct_check("R6 exit direct", 4'h9);
        packed_mode = 1'b1;
        step(1'b1, 4'hA);
        check("R6 restart first", {7'd0, idx_valid}, 8'd0);
        step(1'b1, 4'h5);
        check("R6 restart pair", idx_out, 8'hA5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule